// File: doc/BRIEF.md
# Context Stack Sequencer

This block owns a descending stack pointer and moves processor context between a register snapshot and a byte-wide memory port, one byte per clock. A caller places an operation code on a request port. The block then pushes or pops a single byte, a 2- or 3-byte return address, or a complete 9-byte interrupt frame. When the last byte has moved, the block pulses a completion signal. A stack-reset command returns the pointer to the top of the stack.

The pointer always names the next free byte. A push writes at the pointer and then decrements it. A pop increments the pointer first and then reads at the new value. Only the low `LOW_BITS` bits of the pointer move. The upper bits keep the preset value that `SP_MIN` and `SP_MAX` share. When the stack runs past either end, the pointer wraps to the other end and no indication is raised.

Top module: `ctx_stack_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pointer is set to `SP_MAX`. After release, `op_ready` is high, `op_done` is low and neither memory strobe is active.
- R2: Op code 1 (push byte) writes `push_data` at the current pointer address. The pointer then becomes pointer-1.
- R3: Op code 2 (pop byte) first moves the pointer to pointer+1. It then reads at that address, and the byte appears on `pop_data` when `op_done` is high.
- R4: A decrement from `SP_MIN` gives `SP_MAX`, and an increment from `SP_MAX` gives `SP_MIN`. No flag is raised. The pointer never leaves [`SP_MIN`,`SP_MAX`], and its bits above `LOW_BITS` never change.
- R5: Op code 3 (near call) pushes PC[7:0] and then PC[15:8]. Op code 4 (far call) pushes PC[7:0], then PC[15:8], then PC[23:16].
- R6: Op codes 5 and 6 (near and far return) pop those bytes in reverse order into `pc_out`. A near return sets `pc_out[23:16]` to `pc_in[23:16]` as sampled at the request.
- R7: Op code 7 (interrupt entry) pushes nine bytes in this order: PC[7:0], PC[15:8], PC[23:16], Y[7:0], Y[15:8], X[7:0], X[15:8], A, flags.
- R8: Op code 8 (interrupt return) pops the nine bytes in reverse order, flags first. It restores `pc_out`, `x_out`, `y_out`, `a_out` and `cc_out`.
- R9: Op code 9 (stack reset) sets the pointer to `SP_MAX` without any memory access. `op_done` pulses on the next cycle.
- R10: An accepted frame of L bytes transfers one byte in each of the L cycles that follow acceptance. `op_ready` is low during those cycles. `op_done` is a one-cycle pulse in the cycle after the last transfer.
- R11: A request is ignored, with no strobe, no pointer change and no `op_done`, when `op_ready` is low or when the op code is 0 or 10 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Request strobe |
| op_code | input | 4 | Operation code |
| push_data | input | 8 | Byte for single push |
| pc_in | input | 24 | Program counter snapshot |
| x_in | input | 16 | X index snapshot |
| y_in | input | 16 | Y index snapshot |
| a_in | input | 8 | Accumulator snapshot |
| cc_in | input | 8 | Flags snapshot |
| op_ready | output | 1 | Idle, can accept a request |
| op_done | output | 1 | Operation complete pulse |
| sp_out | output | 16 | Current stack pointer |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid in the same cycle |
| pc_out | output | 24 | Restored program counter |
| x_out | output | 16 | Restored X |
| y_out | output | 16 | Restored Y |
| a_out | output | 8 | Restored accumulator |
| cc_out | output | 8 | Restored flags |
| pop_data | output | 8 | Byte from single pop |

## Verification
The assertions check the following on every cycle:
- the pointer's step size, its wrap at both ends, its range and its fixed upper bits;
- that the two memory strobes are exclusive and one is active whenever the block is busy;
- that `op_done` follows the final transfer.

Only the bench scenarios can show the byte order a frame leaves in memory, the values restored by each kind of return, and the cycle count of each operation. The bench also sweeps the full 512-byte stack of the default configuration in both directions, across both wrap points.

// File: rtl/ctx_stack_pkg.sv
// Shared operation codes and frame helpers for the context stack sequencer.
// Assumes op codes fit four bits; codes outside 1..9 are unused.
package ctx_stack_pkg;

    typedef enum logic [3:0] {
        OP_NONE  = 4'd0,
        OP_PUSH  = 4'd1,
        OP_POP   = 4'd2,
        OP_CALLN = 4'd3,
        OP_CALLF = 4'd4,
        OP_RETN  = 4'd5,
        OP_RETF  = 4'd6,
        OP_IRQ   = 4'd7,
        OP_IRET  = 4'd8,
        OP_SPRST = 4'd9
    } op_e;

    localparam int FRAME_BYTES = 9;

    // Number of bytes an operation moves.
    function automatic logic [3:0] op_len(input logic [3:0] code);
        case (code)
            OP_PUSH, OP_POP:   return 4'd1;
            OP_CALLN, OP_RETN: return 4'd2;
            OP_CALLF, OP_RETF: return 4'd3;
            OP_IRQ, OP_IRET:   return 4'd9;
            default:           return 4'd0;
        endcase
    endfunction

    // True for operations that read from the stack.
    function automatic logic op_is_pop(input logic [3:0] code);
        return (code == OP_POP) || (code == OP_RETN) ||
               (code == OP_RETF) || (code == OP_IRET);
    endfunction

    // True for codes the block acts on.
    function automatic logic op_known(input logic [3:0] code);
        return (code >= OP_PUSH) && (code <= OP_SPRST);
    endfunction

endpackage

// File: rtl/csq_ptr.sv
// Stack pointer register with wrapping step logic.
// Only the low LOW_BITS bits move; SP_MIN and SP_MAX share their upper bits.
// Assumes push, pop and reset requests are mutually exclusive.
module csq_ptr #(
    parameter int                SP_W     = 16,
    parameter int                LOW_BITS = 10,
    parameter logic [SP_W-1:0]   SP_MIN   = 16'h0200,
    parameter logic [SP_W-1:0]   SP_MAX   = 16'h03FF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic            sp_reset,
    output logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] push_addr,
    output logic [SP_W-1:0] pop_addr
);
    localparam logic [LOW_BITS-1:0] LOW_ONE = LOW_BITS'(1);

    logic [SP_W-1:0] sp_q;
    logic [SP_W-1:0] sp_dec;
    logic [SP_W-1:0] sp_inc;

    // Neighbour values with wrap at both ends of the range.
    always_comb begin
        sp_dec = (sp_q == SP_MIN) ? SP_MAX
                 : {sp_q[SP_W-1:LOW_BITS], sp_q[LOW_BITS-1:0] - LOW_ONE};
        sp_inc = (sp_q == SP_MAX) ? SP_MIN
                 : {sp_q[SP_W-1:LOW_BITS], sp_q[LOW_BITS-1:0] + LOW_ONE};
    end

    // Pointer register: reset to top, step on each transferred byte.
    always_ff @(posedge clk) begin
        if (!rst_n || sp_reset) begin
            sp_q <= SP_MAX;
        end else if (push) begin
            sp_q <= sp_dec;
        end else if (pop) begin
            sp_q <= sp_inc;
        end
    end

    assign sp        = sp_q;
    assign push_addr = sp_q;
    assign pop_addr  = sp_inc;

    // R1
    reset_val_chk: assert property (@(posedge clk) !rst_n |=> sp_q == SP_MAX);
    // R4
    in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_q >= SP_MIN) && (sp_q <= SP_MAX));
    // R4
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(sp_q[SP_W-1:LOW_BITS]));
    // R4
    push_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && !sp_reset && sp_q == SP_MIN |=> sp_q == SP_MAX);
    // R4
    pop_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !sp_reset && sp_q == SP_MAX |=> sp_q == SP_MIN);
    // R2
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && !sp_reset && sp_q != SP_MIN |=> sp_q == $past(sp_q) - 1'b1);
    // R3
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !sp_reset && sp_q != SP_MAX |=> sp_q == $past(sp_q) + 1'b1);

endmodule

// File: rtl/csq_frame.sv
// Frame register: loads the register snapshot when an operation starts,
// supplies the byte to push at a given index, and captures popped bytes.
// Byte order by index: PC low, PC mid, PC high, Y low, Y high, X low, X high, A, flags.
// For single-byte operations, index 0 carries push_data / pop_data.
module csq_frame
    import ctx_stack_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic        single,
    input  logic [7:0]  push_data,
    input  logic [23:0] pc_in,
    input  logic [15:0] x_in,
    input  logic [15:0] y_in,
    input  logic [7:0]  a_in,
    input  logic [7:0]  cc_in,
    input  logic        cap,
    input  logic [3:0]  idx,
    input  logic [7:0]  rdata,
    output logic [7:0]  wbyte,
    output logic [23:0] pc_out,
    output logic [15:0] x_out,
    output logic [15:0] y_out,
    output logic [7:0]  a_out,
    output logic [7:0]  cc_out,
    output logic [7:0]  pop_data
);
    logic [7:0] snap [FRAME_BYTES];
    logic [7:0] fr_q [FRAME_BYTES];

    // Snapshot arranged in frame order.
    always_comb begin
        snap[0] = single ? push_data : pc_in[7:0];
        snap[1] = pc_in[15:8];
        snap[2] = pc_in[23:16];
        snap[3] = y_in[7:0];
        snap[4] = y_in[15:8];
        snap[5] = x_in[7:0];
        snap[6] = x_in[15:8];
        snap[7] = a_in;
        snap[8] = cc_in;
    end

    // One byte register per frame slot.
    for (genvar g = 0; g < FRAME_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fr_q[g] <= 8'h00;
            end else if (load) begin
                fr_q[g] <= snap[g];
            end else if (cap && idx == 4'(g)) begin
                fr_q[g] <= rdata;
            end
        end
    end

    // Select the byte to be pushed at the current index.
    always_comb begin
        wbyte = 8'h00;
        for (int i = 0; i < FRAME_BYTES; i++) begin
            if (idx == 4'(i)) wbyte = fr_q[i];
        end
    end

    assign pc_out   = {fr_q[2], fr_q[1], fr_q[0]};
    assign y_out    = {fr_q[4], fr_q[3]};
    assign x_out    = {fr_q[6], fr_q[5]};
    assign a_out    = fr_q[7];
    assign cc_out   = fr_q[8];
    assign pop_data = fr_q[0];

    // R8
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> idx < 4'(FRAME_BYTES));
    // R7
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !cap);

endmodule

// File: rtl/csq_ctrl.sv
// Operation sequencer: accepts a request when idle, then walks the frame
// one byte per clock (ascending index for pushes, descending for pops),
// and pulses done in the cycle after the last byte.
// Assumes op_code is stable in the cycle op_valid is high.
module csq_ctrl
    import ctx_stack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [3:0] op_code,
    output logic       op_ready,
    output logic       start,
    output logic       single,
    output logic       sp_reset,
    output logic       xfer,
    output logic       is_pop,
    output logic [3:0] idx,
    output logic       done
);
    logic       busy_q;
    logic       pop_q;
    logic [3:0] idx_q;
    logic [3:0] left_q;
    logic       done_q;
    logic       accept;

    // Request acceptance and decode.
    always_comb begin
        accept   = op_valid && !busy_q && op_known(op_code);
        start    = accept && (op_code != OP_SPRST);
        sp_reset = accept && (op_code == OP_SPRST);
        single   = (op_code == OP_PUSH) || (op_code == OP_POP);
    end

    // Byte walk state and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pop_q  <= 1'b0;
            idx_q  <= 4'd0;
            left_q <= 4'd0;
            done_q <= 1'b0;
        end else begin
            done_q <= sp_reset || (busy_q && left_q == 4'd1);
            if (start) begin
                busy_q <= 1'b1;
                pop_q  <= op_is_pop(op_code);
                left_q <= op_len(op_code);
                idx_q  <= op_is_pop(op_code) ? op_len(op_code) - 4'd1 : 4'd0;
            end else if (busy_q) begin
                left_q <= left_q - 4'd1;
                idx_q  <= pop_q ? idx_q - 4'd1 : idx_q + 4'd1;
                if (left_q == 4'd1) busy_q <= 1'b0;
            end
        end
    end

    assign op_ready = !busy_q;
    assign xfer     = busy_q;
    assign is_pop   = pop_q;
    assign idx      = idx_q;
    assign done     = done_q;

    // R10
    last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && left_q == 4'd1 |=> done_q && !busy_q);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q && !op_valid |=> !busy_q && !done_q);

endmodule

// File: rtl/ctx_stack_seq.sv
// Top level: descending stack pointer with byte-serial context push/pop.
// Connects the sequencer, pointer and frame register to the memory port.
// Assumes an asynchronous-read memory (mem_rdata valid in the cycle of mem_re).
module ctx_stack_seq #(
    parameter int              SP_W     = 16,
    parameter int              LOW_BITS = 10,
    parameter logic [SP_W-1:0] SP_MIN   = 16'h0200,
    parameter logic [SP_W-1:0] SP_MAX   = 16'h03FF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [3:0]      op_code,
    input  logic [7:0]      push_data,
    input  logic [23:0]     pc_in,
    input  logic [15:0]     x_in,
    input  logic [15:0]     y_in,
    input  logic [7:0]      a_in,
    input  logic [7:0]      cc_in,
    output logic            op_ready,
    output logic            op_done,
    output logic [SP_W-1:0] sp_out,
    output logic            mem_we,
    output logic            mem_re,
    output logic [SP_W-1:0] mem_addr,
    output logic [7:0]      mem_wdata,
    input  logic [7:0]      mem_rdata,
    output logic [23:0]     pc_out,
    output logic [15:0]     x_out,
    output logic [15:0]     y_out,
    output logic [7:0]      a_out,
    output logic [7:0]      cc_out,
    output logic [7:0]      pop_data
);
    logic            start, single, sp_reset, xfer, is_pop;
    logic [3:0]      idx;
    logic [SP_W-1:0] push_addr, pop_addr;
    logic [7:0]      wbyte;

    csq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .op_ready (op_ready),
        .start    (start),
        .single   (single),
        .sp_reset (sp_reset),
        .xfer     (xfer),
        .is_pop   (is_pop),
        .idx      (idx),
        .done     (op_done)
    );

    csq_ptr #(
        .SP_W     (SP_W),
        .LOW_BITS (LOW_BITS),
        .SP_MIN   (SP_MIN),
        .SP_MAX   (SP_MAX)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (xfer && !is_pop),
        .pop       (xfer && is_pop),
        .sp_reset  (sp_reset),
        .sp        (sp_out),
        .push_addr (push_addr),
        .pop_addr  (pop_addr)
    );

    csq_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .single    (single),
        .push_data (push_data),
        .pc_in     (pc_in),
        .x_in      (x_in),
        .y_in      (y_in),
        .a_in      (a_in),
        .cc_in     (cc_in),
        .cap       (xfer && is_pop),
        .idx       (idx),
        .rdata     (mem_rdata),
        .wbyte     (wbyte),
        .pc_out    (pc_out),
        .x_out     (x_out),
        .y_out     (y_out),
        .a_out     (a_out),
        .cc_out    (cc_out),
        .pop_data  (pop_data)
    );

    // Memory port drive: write at pointer on push, read at incremented pointer on pop.
    always_comb begin
        mem_we    = xfer && !is_pop;
        mem_re    = xfer && is_pop;
        mem_addr  = is_pop ? pop_addr : push_addr;
        mem_wdata = wbyte;
    end

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));
    // R10
    busy_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_ready |-> (mem_we || mem_re));
    // R9
    sprst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_ready && op_valid && op_code == 4'd9 |=> !mem_we && !mem_re && op_done);

endmodule

// File: tb/ctx_stack_seq_test.sv
module ctx_stack_seq_test;
    localparam logic [15:0] SMIN = 16'h0200;
    localparam logic [15:0] SMAX = 16'h03FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [7:0]  push_data = 8'h00;
    logic [23:0] pc_in = 24'h0;
    logic [15:0] x_in = 16'h0, y_in = 16'h0;
    logic [7:0]  a_in = 8'h0, cc_in = 8'h0;
    logic        op_ready, op_done, mem_we, mem_re;
    logic [15:0] sp_out, mem_addr;
    logic [7:0]  mem_wdata, mem_rdata, a_out, cc_out, pop_data;
    logic [23:0] pc_out;
    logic [15:0] x_out, y_out;

    logic [7:0] mem [0:1023];
    int errors = 0;
    int checks = 0;
    int writes = 0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    ctx_stack_seq uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .push_data(push_data), .pc_in(pc_in), .x_in(x_in), .y_in(y_in),
        .a_in(a_in), .cc_in(cc_in), .op_ready(op_ready), .op_done(op_done),
        .sp_out(sp_out), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_out(pc_out),
        .x_out(x_out), .y_out(y_out), .a_out(a_out), .cc_out(cc_out),
        .pop_data(pop_data)
    );

    assign mem_rdata = mem[mem_addr[9:0]];
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[9:0]] <= mem_wdata;
            writes <= writes + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] dec_sp(input logic [15:0] s);
        return (s == SMIN) ? SMAX : s - 16'd1;
    endfunction

    // Issue one request and count negedges until done (cap 40).
    task automatic run_op(input logic [3:0] code, output int cyc);
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = code;
        @(negedge clk);
        op_valid = 1'b0;
        cyc = 1;
        while (!op_done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int cyc;
        logic [15:0] exp_sp;
        int w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sp", sp_out, SMAX);
        chk("R1 ready", op_ready, 1);
        chk("R1 strobes", {op_done, mem_we, mem_re}, 0);

        // R2 / R3 single byte
        push_data = 8'hC7;
        run_op(4'd1, cyc);
        chk("R2 mem", mem[10'h3FF], 8'hC7);
        chk("R2 sp", sp_out, 16'h03FE);
        chk("R10 push1 cycles", cyc, 2);
        run_op(4'd2, cyc);
        chk("R3 data", pop_data, 8'hC7);
        chk("R3 sp", sp_out, SMAX);

        // R5 / R6 near call and return
        pc_in = 24'h123456;
        run_op(4'd3, cyc);
        chk("R5 near lo", mem[10'h3FF], 8'h56);
        chk("R5 near hi", mem[10'h3FE], 8'h34);
        chk("R5 near sp", sp_out, 16'h03FD);
        chk("R10 near cycles", cyc, 3);
        pc_in = 24'h77AAAA;
        run_op(4'd5, cyc);
        chk("R6 near pc", pc_out, 24'h773456);
        chk("R6 near sp", sp_out, SMAX);

        // R5 / R6 far call and return
        pc_in = 24'h9ABCDE;
        run_op(4'd4, cyc);
        chk("R5 far b0", mem[10'h3FF], 8'hDE);
        chk("R5 far b1", mem[10'h3FE], 8'hBC);
        chk("R5 far b2", mem[10'h3FD], 8'h9A);
        chk("R10 far cycles", cyc, 4);
        pc_in = 24'h000000;
        run_op(4'd6, cyc);
        chk("R6 far pc", pc_out, 24'h9ABCDE);
        chk("R6 far sp", sp_out, SMAX);

        // R7 interrupt entry, with a request made while busy (R11)
        pc_in = 24'hA1B2C3; x_in = 16'hD4E5; y_in = 16'hF607; a_in = 8'h18; cc_in = 8'h29;
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'd7;
        @(negedge clk);
        op_code = 4'd9; // stack reset offered while busy: must be ignored
        chk("R10 ready low", op_ready, 0);
        @(negedge clk);
        op_valid = 1'b0;
        cyc = 2;
        while (!op_done && cyc < 40) begin @(negedge clk); cyc++; end
        chk("R10 irq cycles", cyc, 10);
        chk("R7 b0", mem[10'h3FF], 8'hC3);
        chk("R7 b1", mem[10'h3FE], 8'hB2);
        chk("R7 b2", mem[10'h3FD], 8'hA1);
        chk("R7 b3", mem[10'h3FC], 8'h07);
        chk("R7 b4", mem[10'h3FB], 8'hF6);
        chk("R7 b5", mem[10'h3FA], 8'hE5);
        chk("R7 b6", mem[10'h3F9], 8'hD4);
        chk("R7 b7", mem[10'h3F8], 8'h18);
        chk("R7 b8", mem[10'h3F7], 8'h29);
        chk("R11 busy ignored sp", sp_out, 16'h03F6);
        @(negedge clk);
        chk("R10 done pulse", op_done, 0);

        // R8 interrupt return
        pc_in = 24'h0; x_in = 16'h0; y_in = 16'h0; a_in = 8'h0; cc_in = 8'h0;
        run_op(4'd8, cyc);
        chk("R8 pc", pc_out, 24'hA1B2C3);
        chk("R8 x", x_out, 16'hD4E5);
        chk("R8 y", y_out, 16'hF607);
        chk("R8 a", a_out, 8'h18);
        chk("R8 cc", cc_out, 8'h29);
        chk("R8 sp", sp_out, SMAX);

        // R11 unused codes
        w0 = writes;
        foreach (op_code[i]) begin end
        for (int c = 0; c < 16; c++) begin
            if (c == 0 || c >= 10) begin
                @(negedge clk);
                op_valid = 1'b1; op_code = 4'(c);
                @(negedge clk);
                op_valid = 1'b0;
                chk("R11 no done", {op_done, mem_we, mem_re, !op_ready}, 0);
                @(negedge clk);
                chk("R11 no done later", op_done, 0);
            end
        end
        chk("R11 sp", sp_out, SMAX);
        chk("R11 writes", writes, w0);

        // R9 stack reset after some pushes
        run_op(4'd1, cyc);
        run_op(4'd1, cyc);
        w0 = writes;
        run_op(4'd9, cyc);
        chk("R9 sp", sp_out, SMAX);
        chk("R9 cycles", cyc, 1);
        chk("R9 no write", writes, w0);

        // R4 full sweep: 512 pushes across the lower wrap, then 512 pops
        exp_sp = SMAX;
        for (int i = 0; i < 512; i++) begin
            push_data = 8'(i) ^ 8'h5A;
            run_op(4'd1, cyc);
            exp_sp = dec_sp(exp_sp);
            chk("R4 push sweep sp", sp_out, exp_sp);
        end
        chk("R4 min slot", mem[10'h200], 8'(511) ^ 8'h5A);
        for (int i = 511; i >= 0; i--) begin
            run_op(4'd2, cyc);
            chk("R4 pop sweep data", pop_data, 8'(i) ^ 8'h5A);
            chk("R4 upper bits", sp_out[15:10], 6'd0);
        end
        chk("R4 sweep end sp", sp_out, SMAX);

        finish_run();
    end
endmodule